// File: doc/BRIEF.md
# Dual-Path Storing Bus Transceiver

This block is an 18-bit, two-port transceiver. It has one storage path that carries data from port A to port B and a second path that carries data from port B to port A. Each path has its own four controls: a pass control, a bus strobe, an active-low strobe enable and an active-low drive control. The two paths share none of these controls.

Each path holds its data in a single storage element, which works in one of three modes:

- **Transparent:** while pass is high, the output follows the input.
- **Held:** while pass is low, the stored word stays in place.
- **Edge-clocked:** while pass is low, a rising edge of the bus strobe captures the input word, as long as the strobe enable is low.

Each port appears as three vectors: input data, output data and a per-bit output enable. On a real pad these vectors would feed a tri-state driver.

The block runs on a core clock. Each bus strobe passes through `SYNC_STAGES` synchronising flops and then an edge detector. The core reset clears only these control flops and never clears stored data. The stored value is undefined until the first transparent load or the first capture. The bench never enables both paths' drivers onto one port with conflicting data.

Top module: `dual_path_xcvr`

## Requirements
- R1: While a path's pass input is 1, that path's output data equals its input data in the same cycle, whatever the strobe and strobe enable are doing.
- R2: While pass is 0 and no rising strobe edge is recognised, the output data stays constant even when the input data changes.
- R3: With pass 0 and strobe enable 0, a 0-to-1 change of the bus strobe captures the input word. The new value appears at the output after exactly SYNC_STAGES+1 core clock rising edges, counted from the change of the strobe. It is not visible one edge earlier.
- R4: While the strobe enable is 1, rising strobe edges do not change the stored word.
- R5: A 1-to-0 change of the bus strobe does not change the stored word.
- R6: When pass falls from 1 to 0, the output keeps the input word that was present at the last core clock edge before pass fell. Later input changes do not affect it.
- R7: The output enable vector is all ones when the drive control is 0 and all zeros when the drive control is 1.
- R8: The drive control affects only the output enables. A capture made while the drive control is 1 is shown once the drive control returns to 0.
- R9: The two paths are independent. Loads, captures and drive changes on one path leave the other path's output data and output enables unchanged.
- R10: A bus strobe that is already 1 when the core reset is released is not treated as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset of strobe synchronisers and edge detectors |
| aIn | input | WIDTH | Data received on port A |
| aOut | output | WIDTH | Data from the B-to-A path, presented on port A |
| aOutEn | output | WIDTH | Per-bit drive enable for port A |
| bIn | input | WIDTH | Data received on port B |
| bOut | output | WIDTH | Data from the A-to-B path, presented on port B |
| bOutEn | output | WIDTH | Per-bit drive enable for port B |
| abPass | input | 1 | A-to-B transparent control, active high |
| abStrobe | input | 1 | A-to-B bus strobe, captures on its rising edge |
| abStrobeEnN | input | 1 | A-to-B strobe enable, active low |
| abDriveN | input | 1 | A-to-B drive control onto port B, active low |
| baPass | input | 1 | B-to-A transparent control, active high |
| baStrobe | input | 1 | B-to-A bus strobe, captures on its rising edge |
| baStrobeEnN | input | 1 | B-to-A strobe enable, active low |
| baDriveN | input | 1 | B-to-A drive control onto port A, active low |

## Verification
The bench builds the block with WIDTH = 18 and SYNC_STAGES = 1. Every data bit is therefore live, and the capture latency of two core edges can be checked on both sides of its boundary. One synchroniser stage is enough to exercise the reset rule for a strobe that is already high, and the falling-edge and gated-edge cases. Both paths are driven with distinct patterns, so crosstalk between the directions would show up on the outputs.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Strobes passed from a path's control to its datapath
  typedef struct packed {
    logic pass;   // transparent bypass
    logic load;   // write storage at this core edge
    logic drive;  // enable output drivers
  } pathCtl_t;

endpackage

// File: rtl/xcvr_path_ctrl.sv
module xcvr_path_ctrl
  import xcvr_pkg::*;
#(
  parameter int SYNC_STAGES = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pass,
  input  logic     strobe,
  input  logic     strobeEnN,
  input  logic     driveN,
  output pathCtl_t ctl
);

  logic syncLvl;
  logic prevLvl;
  logic riseSeen;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign syncLvl = strobe;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      // Reset to ones so a strobe already high at release is not an edge
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '1;
        end else begin
          chain[0] <= strobe;
          for (int i = 1; i < SYNC_STAGES; i++) begin
            chain[i] <= chain[i-1];
          end
        end
      end
      assign syncLvl = chain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevLvl <= 1'b1;
    else        prevLvl <= syncLvl;
  end

  assign riseSeen = syncLvl & ~prevLvl;

  always_comb begin
    ctl.pass  = pass;
    ctl.load  = pass | (riseSeen & ~strobeEnN);
    ctl.drive = ~driveN;
  end

endmodule

// File: rtl/xcvr_path_data.sv
module xcvr_path_data
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  input  pathCtl_t         ctl,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] doutEn
);

  logic [WIDTH-1:0] held;

  // Storage has no reset: contents are defined by the first load
  always_ff @(posedge clk) begin
    if (ctl.load) held <= din;
  end

  assign dout   = ctl.pass ? din : held;
  assign doutEn = {WIDTH{ctl.drive}};

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH       = 18,
  parameter int SYNC_STAGES = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] aOutEn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] bOutEn,
  input  logic             abPass,
  input  logic             abStrobe,
  input  logic             abStrobeEnN,
  input  logic             abDriveN,
  input  logic             baPass,
  input  logic             baStrobe,
  input  logic             baStrobeEnN,
  input  logic             baDriveN
);

  pathCtl_t abCtl;
  pathCtl_t baCtl;

  xcvr_path_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_abCtrl (
    .clk(clk), .rst_n(rst_n), .pass(abPass), .strobe(abStrobe),
    .strobeEnN(abStrobeEnN), .driveN(abDriveN), .ctl(abCtl)
  );

  xcvr_path_data #(.WIDTH(WIDTH)) u_abData (
    .clk(clk), .din(aIn), .ctl(abCtl), .dout(bOut), .doutEn(bOutEn)
  );

  xcvr_path_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_baCtrl (
    .clk(clk), .rst_n(rst_n), .pass(baPass), .strobe(baStrobe),
    .strobeEnN(baStrobeEnN), .driveN(baDriveN), .ctl(baCtl)
  );

  xcvr_path_data #(.WIDTH(WIDTH)) u_baData (
    .clk(clk), .din(bIn), .ctl(baCtl), .dout(aOut), .doutEn(aOutEn)
  );

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] aOut,
  input logic [WIDTH-1:0] aOutEn,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] bOut,
  input logic [WIDTH-1:0] bOutEn,
  input logic             abPass,
  input logic             abStrobeEnN,
  input logic             abDriveN,
  input logic             baPass,
  input logic             baStrobeEnN,
  input logic             baDriveN,
  input pathCtl_t         abCtl,
  input pathCtl_t         baCtl
);

  // R1
  p_pass_ab_r1: assert property (@(posedge clk) disable iff (!rst_n)
    abPass |-> bOut == aIn);
  p_pass_ba_r1: assert property (@(posedge clk) disable iff (!rst_n)
    baPass |-> aOut == bIn);

  // R2
  p_hold_ab_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!abPass && !abCtl.load) ##1 !abPass |-> $stable(bOut));
  p_hold_ba_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!baPass && !baCtl.load) ##1 !baPass |-> $stable(aOut));

  // R3
  p_capture_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!abPass && abCtl.load) |=> (abPass || bOut == $past(aIn)));
  p_capture_ba_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!baPass && baCtl.load) |=> (baPass || aOut == $past(bIn)));

  // R4
  p_gate_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (abStrobeEnN && !abPass) |-> !abCtl.load);
  p_gate_ba_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (baStrobeEnN && !baPass) |-> !baCtl.load);

  // R7
  p_drive_ab_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bOutEn == {WIDTH{!abDriveN}});
  p_drive_ba_r7: assert property (@(posedge clk) disable iff (!rst_n)
    aOutEn == {WIDTH{!baDriveN}});

endmodule

bind dual_path_xcvr xcvr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .aIn(aIn), .aOut(aOut), .aOutEn(aOutEn),
  .bIn(bIn), .bOut(bOut), .bOutEn(bOutEn),
  .abPass(abPass), .abStrobeEnN(abStrobeEnN), .abDriveN(abDriveN),
  .baPass(baPass), .baStrobeEnN(baStrobeEnN), .baDriveN(baDriveN),
  .abCtl(abCtl), .baCtl(baCtl)
);

// File: tb/sim_dual_path_xcvr.sv
module sim_dual_path_xcvr;

  localparam int W    = 18;
  localparam int SYNC = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] aIn, bIn;
  logic [W-1:0] aOut, aOutEn, bOut, bOutEn;
  logic abPass, abStrobe, abStrobeEnN, abDriveN;
  logic baPass, baStrobe, baStrobeEnN, baDriveN;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dual_path_xcvr #(.WIDTH(W), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .aIn(aIn), .aOut(aOut), .aOutEn(aOutEn),
    .bIn(bIn), .bOut(bOut), .bOutEn(bOutEn),
    .abPass(abPass), .abStrobe(abStrobe), .abStrobeEnN(abStrobeEnN), .abDriveN(abDriveN),
    .baPass(baPass), .baStrobe(baStrobe), .baStrobeEnN(baStrobeEnN), .baDriveN(baDriveN)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // n core rising edges, then return at the following falling edge
  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_edge();
    // R10 / R1: load 0x0AAAA during reset through pass, then hold strobe high at release
    rst_n = 1'b0;
    abPass = 1'b1; aIn = 18'h0AAAA; abStrobe = 1'b1; abStrobeEnN = 1'b0; abDriveN = 1'b0;
    baPass = 1'b1; bIn = 18'h15555; baStrobe = 1'b1; baStrobeEnN = 1'b0; baDriveN = 1'b0;
    ticks(3);
    #1 check("R1 pass during reset", bOut, 18'h0AAAA);
    abPass = 1'b0; baPass = 1'b0;
    aIn = 18'h3FFFF; bIn = 18'h00000;
    ticks(1);
    rst_n = 1'b1;
    ticks(4);
    check("R10 ab strobe high at release", bOut, 18'h0AAAA);
    check("R10 ba strobe high at release", aOut, 18'h15555);
  endtask

  task automatic t_capture();
    // R3: rising strobe captures after SYNC+1 edges, not earlier
    abStrobe = 1'b0; ticks(3);
    aIn = 18'h12345;
    abStrobe = 1'b1;
    ticks(SYNC);
    check("R3 not yet captured", bOut, 18'h0AAAA);
    ticks(1);
    check("R3 captured", bOut, 18'h12345);
    // R2: data changes with no edge
    aIn = 18'h2F0F0; ticks(4);
    check("R2 hold on data change", bOut, 18'h12345);
    // R5: falling edge does not capture
    abStrobe = 1'b0; ticks(4);
    check("R5 falling edge ignored", bOut, 18'h12345);
  endtask

  task automatic t_gate();
    // R4: strobe enable high blocks a rising edge
    abStrobeEnN = 1'b1; aIn = 18'h00F0F;
    abStrobe = 1'b1; ticks(4);
    check("R4 gated edge ignored", bOut, 18'h12345);
    abStrobe = 1'b0; ticks(3);
    abStrobeEnN = 1'b0;
  endtask

  task automatic t_pass_fall();
    // R6: value before pass falls is kept
    abPass = 1'b1; aIn = 18'h1C3C3;
    #1 check("R1 pass follows", bOut, 18'h1C3C3);
    ticks(1);
    abPass = 1'b0; aIn = 18'h03C3C;
    #1 check("R6 kept at pass fall", bOut, 18'h1C3C3);
    ticks(3);
    check("R6 still kept", bOut, 18'h1C3C3);
    // R1: pass dominates strobe activity
    abPass = 1'b1; abStrobe = 1'b1; aIn = 18'h00001;
    #1 check("R1 pass over strobe", bOut, 18'h00001);
    ticks(2); abStrobe = 1'b0; abPass = 1'b0; ticks(3);
  endtask

  task automatic t_drive();
    // R7 / R8
    abDriveN = 1'b1;
    #1 check("R7 enables off", bOutEn, 18'h00000);
    aIn = 18'h2AAAA; abStrobe = 1'b1; ticks(3);
    abDriveN = 1'b0;
    #1 check("R7 enables on", bOutEn, 18'h3FFFF);
    check("R8 capture while disabled", bOut, 18'h2AAAA);
    abStrobe = 1'b0; ticks(3);
  endtask

  task automatic t_independent();
    // R9: B-to-A activity leaves A-to-B untouched, and vice versa
    baStrobe = 1'b0; ticks(3);
    bIn = 18'h0BEEF; baStrobe = 1'b1; baDriveN = 1'b1;
    ticks(3);
    check("R9 ba captured", aOut, 18'h0BEEF);
    check("R9 ab data unaffected", bOut, 18'h2AAAA);
    check("R9 ab enables unaffected", bOutEn, 18'h3FFFF);
    check("R7 ba enables off", aOutEn, 18'h00000);
    abPass = 1'b1; aIn = 18'h11111; ticks(2);
    check("R9 ba data unaffected", aOut, 18'h0BEEF);
    abPass = 1'b0; baDriveN = 1'b0; ticks(1);
  endtask

  initial begin
    t_reset_edge();
    t_capture();
    t_gate();
    t_pass_fall();
    t_drive();
    t_independent();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule